// File: doc/BRIEF.md
# Parallel Port Mode Controller

This block is the mode decoder for a host-side parallel port. Software picks one of eight operating codes through a 3-bit mode field and sets a direction bit. The block turns these two values into driver controls for the port. The controls are the output enable of the eight data lines, an open-drain or push-pull select for each of the four control lines, and the source that a data-register read returns. The block also gives the data path a FIFO reset, an enable for the two configuration registers, and one strobe per transfer engine. The pads, the handshake engines and the FIFO storage are outside the block.

The mode field feeds a registered state machine. Its states are ST_STD, ST_PS2, ST_FIFO, ST_ECP, ST_EPP, ST_EPP_OFF, ST_TEST and ST_CFG. On every clock the machine moves to the state that the stored code selects. Code 000 and the reserved code 101 go to ST_STD. Code 001 goes to ST_PS2, 010 to ST_FIFO, 011 to ST_ECP and 110 to ST_TEST. Code 100 goes to ST_EPP when the `epp_ok` input is 1 and to ST_EPP_OFF when it is 0. Code 111 goes to ST_CFG. Any state can reach any other state in a single step.

The register bus has separate write and read ports. Reads are combinational and qualified by `rd_en`. The register offsets are: data register 0x000, control register 0x002 (direction in bit 5), extended control register 0x402 (mode in bits 7:5), configuration A at 0x400 and configuration B at 0x401.

Top module: `pport_mode_ctrl`

## Requirements
- R1: After reset the mode field reads 000 and the direction bit reads 0. `fifo_rst` is 1, `pd_oe` is 1 and `ctl_od` is 4'hF.
- R2: A write to offset 0x402 stores `wr_data[7:5]` as the mode code. Every code is stored, including the reserved 101. A read of 0x402 returns the code in bits 7:5 and zeros in the other bits. A new code changes the port outputs only after the second rising edge that follows the write cycle. The edge that stores the code does not change them.
- R3: In codes 000 and 101, `fifo_rst` is 1, `ctl_od` is 4'hF (open-drain) and `pd_oe` is 1 whatever the direction bit is.
- R4: In every other code, `fifo_rst` is 0, `ctl_od` is 4'h0 (push-pull) and `pd_oe` is the inverse of the direction bit.
- R5: A read of offset 0x000 returns `pd_in` in code 001 and the last byte written to 0x000 in every other code. `pd_out` always carries the written byte.
- R6: `sel_fifo` is high in code 010, `sel_ecp` in code 011, `sel_test` in code 110, and `sel_epp` in code 100 only while `epp_ok` is 1. At most one strobe is high at a time. No strobe is high in code 100 while `epp_ok` is 0.
- R7: `cfg_en` is 1 only in code 111. Only then does a read of 0x400 return the parameter CFGA_VALUE (default 8'h14) and a read of 0x401 return configuration B. In every other code both offsets read 0. Writes to 0x400 and 0x401 have no effect.
- R8: Configuration B bits 5:3 encode `irq_num` as 15→110, 14→101, 11→100, 10→011, 9→010, 7→001 and 5→111. Any other value gives 000. Bits 7:6 read 0.
- R9: Configuration B bits 2:0 encode `dma_num` as 3→011, 2→010 and 1→001. Any other value gives 000.
- R10: The direction bit is bit 5 of offset 0x002. It reads back in place with the other bits 0, and it acts on `pd_oe` right after the edge that stores it.
- R11: Reads of unmapped offsets, and any cycle with `rd_en` low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 11 | Write offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 11 | Read offset |
| rd_data | output | 8 | Read data, combinational |
| pd_in | input | 8 | Values sensed on the data pins |
| pd_out | output | 8 | Data register value driven to the pins |
| pd_oe | output | 1 | Data pin output enable |
| ctl_od | output | 4 | Per control line: 1 = open-drain, 0 = push-pull |
| fifo_rst | output | 1 | Holds the FIFO in reset |
| cfg_en | output | 1 | Configuration registers reachable |
| sel_fifo | output | 1 | Compatible-FIFO engine strobe |
| sel_ecp | output | 1 | Extended-capability engine strobe |
| sel_epp | output | 1 | Enhanced-port engine strobe |
| sel_test | output | 1 | FIFO test strobe |
| epp_ok | input | 1 | Enhanced-port support enabled |
| irq_num | input | 4 | Selected interrupt number |
| dma_num | input | 3 | Selected DMA channel |

## Verification
A mode write and a register read can fall in the same cycle. The interesting cases are a write of code 001 while the data register is read, and a write of code 111 while configuration A is read. The bench drives both strobes in one cycle. It expects the read in that cycle and the read in the next cycle to follow the old mode, because the state only updates on the edge after the one that stores the code. The new mode is expected to govern the read one cycle after that. A read of 0x402 in the same cycle as a write to 0x402 must return the previous code.

// File: rtl/pport_mode_pkg.sv
package pport_mode_pkg;

    localparam int MODE_W = 3;
    localparam int CTL_LINES = 4;

    typedef enum logic [MODE_W-1:0] {
        M_STD  = 3'b000,
        M_PS2  = 3'b001,
        M_FIFO = 3'b010,
        M_ECP  = 3'b011,
        M_EPP  = 3'b100,
        M_RSVD = 3'b101,
        M_TEST = 3'b110,
        M_CFG  = 3'b111
    } mode_code_e;

    typedef enum logic [2:0] {
        ST_STD,
        ST_PS2,
        ST_FIFO,
        ST_ECP,
        ST_EPP,
        ST_EPP_OFF,
        ST_TEST,
        ST_CFG
    } port_state_e;

    typedef struct packed {
        logic                 data_oe;
        logic [CTL_LINES-1:0] ctl_od;
        logic                 pin_rd;
        logic                 fifo_rst;
        logic                 cfg_en;
        logic                 sel_fifo;
        logic                 sel_ecp;
        logic                 sel_epp;
        logic                 sel_test;
    } drv_ctrl_t;

endpackage

// File: rtl/pport_regs.sv
module pport_regs
    import pport_mode_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int OFF_DATA = 'h000,
    parameter int OFF_CTRL = 'h002,
    parameter int OFF_ECR  = 'h402,
    parameter int DIR_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] data_q,
    output logic              dir_q,
    output logic [MODE_W-1:0] mode_q
);
    localparam int MODE_LSB = DATA_W - MODE_W;

    logic hit_data, hit_ctrl, hit_ecr;

    always_comb begin
        hit_data = wr_en && (wr_addr == ADDR_W'(OFF_DATA));
        hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
        hit_ecr  = wr_en && (wr_addr == ADDR_W'(OFF_ECR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= 1'b0;
            mode_q <= M_STD;
        end else begin
            if (hit_data) data_q <= wr_data;
            if (hit_ctrl) dir_q  <= wr_data[DIR_BIT];
            if (hit_ecr)  mode_q <= wr_data[MODE_LSB +: MODE_W];
        end
    end

    // the reserved code is kept, not filtered
    a_r2_rsvd_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ecr && wr_data[MODE_LSB +: MODE_W] == M_RSVD) |=> (mode_q == M_RSVD));

endmodule

// File: rtl/pport_cfg_encode.sv
module pport_cfg_encode #(
    parameter int DATA_W = 8,
    parameter int IRQ_W  = 4,
    parameter int DMA_W  = 3
) (
    input  logic [IRQ_W-1:0]  irq_num,
    input  logic [DMA_W-1:0]  dma_num,
    output logic [DATA_W-1:0] cfgb
);
    localparam int CODE_W = 3;

    logic [CODE_W-1:0] irq_code, dma_code;

    always_comb begin
        unique case (irq_num)
            IRQ_W'(15): irq_code = 3'b110;
            IRQ_W'(14): irq_code = 3'b101;
            IRQ_W'(11): irq_code = 3'b100;
            IRQ_W'(10): irq_code = 3'b011;
            IRQ_W'(9):  irq_code = 3'b010;
            IRQ_W'(7):  irq_code = 3'b001;
            IRQ_W'(5):  irq_code = 3'b111;
            default:    irq_code = 3'b000;
        endcase
        unique case (dma_num)
            DMA_W'(3): dma_code = 3'b011;
            DMA_W'(2): dma_code = 3'b010;
            DMA_W'(1): dma_code = 3'b001;
            default:   dma_code = 3'b000;
        endcase
        cfgb = '0;
        cfgb[2*CODE_W-1:CODE_W] = irq_code;
        cfgb[CODE_W-1:0]        = dma_code;
    end

endmodule

// File: rtl/pport_mode_fsm.sv
module pport_mode_fsm
    import pport_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              epp_ok,
    input  logic              dir_q,
    output drv_ctrl_t         drv
);
    port_state_e st_q, st_d;

    // next-state selection from the stored code
    always_comb begin
        st_d = ST_STD;
        unique case (mode_code_e'(mode_q))
            M_STD:  st_d = ST_STD;
            M_PS2:  st_d = ST_PS2;
            M_FIFO: st_d = ST_FIFO;
            M_ECP:  st_d = ST_ECP;
            M_EPP:  st_d = epp_ok ? ST_EPP : ST_EPP_OFF;
            M_RSVD: st_d = ST_STD;
            M_TEST: st_d = ST_TEST;
            M_CFG:  st_d = ST_CFG;
            default: st_d = ST_STD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STD;
        else        st_q <= st_d;
    end

    // outputs from state
    always_comb begin
        drv          = '0;
        drv.data_oe  = !dir_q;
        unique case (st_q)
            ST_STD: begin
                drv.data_oe  = 1'b1;
                drv.ctl_od   = '1;
                drv.fifo_rst = 1'b1;
            end
            ST_PS2:     drv.pin_rd   = 1'b1;
            ST_FIFO:    drv.sel_fifo = 1'b1;
            ST_ECP:     drv.sel_ecp  = 1'b1;
            ST_EPP:     drv.sel_epp  = 1'b1;
            ST_EPP_OFF: drv.sel_epp  = 1'b0;
            ST_TEST:    drv.sel_test = 1'b1;
            ST_CFG:     drv.cfg_en   = 1'b1;
            default:    drv.fifo_rst = 1'b1;
        endcase
    end

    a_r3_oe_while_fifo_rst: assert property (@(posedge clk) disable iff (!rst_n)
        drv.fifo_rst |-> drv.data_oe);

    a_r4_od_only_in_std: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv.ctl_od) |-> drv.fifo_rst);

    a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv.sel_fifo, drv.sel_ecp, drv.sel_epp, drv.sel_test, drv.cfg_en, drv.fifo_rst}));

    a_r6_epp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        drv.sel_epp |-> $past(epp_ok));

endmodule

// File: rtl/pport_mode_ctrl.sv
module pport_mode_ctrl
    import pport_mode_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int IRQ_W      = 4,
    parameter int DMA_W      = 3,
    parameter int OFF_DATA   = 'h000,
    parameter int OFF_CTRL   = 'h002,
    parameter int OFF_CFGA   = 'h400,
    parameter int OFF_CFGB   = 'h401,
    parameter int OFF_ECR    = 'h402,
    parameter int DIR_BIT    = 5,
    parameter logic [7:0] CFGA_VALUE = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pd_in,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    output logic [3:0]        ctl_od,
    output logic              fifo_rst,
    output logic              cfg_en,
    output logic              sel_fifo,
    output logic              sel_ecp,
    output logic              sel_epp,
    output logic              sel_test,
    input  logic              epp_ok,
    input  logic [IRQ_W-1:0]  irq_num,
    input  logic [DMA_W-1:0]  dma_num
);
    localparam int MODE_LSB = DATA_W - MODE_W;

    logic [DATA_W-1:0] data_q, cfgb;
    logic              dir_q;
    logic [MODE_W-1:0] mode_q;
    drv_ctrl_t         drv;

    pport_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_DATA(OFF_DATA),
        .OFF_CTRL(OFF_CTRL), .OFF_ECR(OFF_ECR), .DIR_BIT(DIR_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q)
    );

    pport_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .epp_ok(epp_ok),
        .dir_q(dir_q), .drv(drv)
    );

    pport_cfg_encode #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .DMA_W(DMA_W)) u_cfg (
        .irq_num(irq_num), .dma_num(dma_num), .cfgb(cfgb)
    );

    assign pd_out   = data_q;
    assign pd_oe    = drv.data_oe;
    assign ctl_od   = drv.ctl_od;
    assign fifo_rst = drv.fifo_rst;
    assign cfg_en   = drv.cfg_en;
    assign sel_fifo = drv.sel_fifo;
    assign sel_ecp  = drv.sel_ecp;
    assign sel_epp  = drv.sel_epp;
    assign sel_test = drv.sel_test;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(OFF_DATA))
                rd_data = drv.pin_rd ? pd_in : data_q;
            else if (rd_addr == ADDR_W'(OFF_CTRL))
                rd_data[DIR_BIT] = dir_q;
            else if (rd_addr == ADDR_W'(OFF_ECR))
                rd_data[MODE_LSB +: MODE_W] = mode_q;
            else if (rd_addr == ADDR_W'(OFF_CFGA) && drv.cfg_en)
                rd_data = DATA_W'(CFGA_VALUE);
            else if (rd_addr == ADDR_W'(OFF_CFGB) && drv.cfg_en)
                rd_data = cfgb;
        end
    end

    a_r2_std_after_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFF_ECR) && wr_data[MODE_LSB +: MODE_W] == M_STD)
        |=> ##1 fifo_rst);

    a_r2_test_after_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFF_ECR) && wr_data[MODE_LSB +: MODE_W] == M_TEST)
        |=> ##1 sel_test);

    a_r7_cfg_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cfg_en && (rd_addr == ADDR_W'(OFF_CFGA) || rd_addr == ADDR_W'(OFF_CFGB)))
        |-> (rd_data == '0));

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

endmodule

// File: tb/pport_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pport_mode_ctrl_bench;
    localparam int AW = 11;
    localparam logic [AW-1:0] A_DATA = 11'h000, A_CTRL = 11'h002,
                              A_CFGA = 11'h400, A_CFGB = 11'h401, A_ECR = 11'h402;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, epp_ok = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, pd_in = '0, rd_data, pd_out;
    logic pd_oe, fifo_rst, cfg_en, sel_fifo, sel_ecp, sel_epp, sel_test;
    logic [3:0] ctl_od, irq_num = '0;
    logic [2:0] dma_num = '0;

    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    pport_mode_ctrl u_pport_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pd_in(pd_in),
        .pd_out(pd_out), .pd_oe(pd_oe), .ctl_od(ctl_od), .fifo_rst(fifo_rst),
        .cfg_en(cfg_en), .sel_fifo(sel_fifo), .sel_ecp(sel_ecp), .sel_epp(sel_epp),
        .sel_test(sel_test), .epp_ok(epp_ok), .irq_num(irq_num), .dma_num(dma_num)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_mode(input logic [2:0] code);
        do_write(A_ECR, {code, 5'b0});
        @(negedge clk);
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        #1;
        chk(rd_data === exp, tag, rd_data, exp);
        rd_en = 0;
    endtask

    task automatic t_reset;
        chk(fifo_rst === 1'b1, "R1 fifo_rst", fifo_rst, 1);
        chk(pd_oe === 1'b1, "R1 pd_oe", pd_oe, 1);
        chk(ctl_od === 4'hF, "R1 ctl_od", ctl_od, 4'hF);
        read_chk(A_ECR, 8'h00, "R1 mode");
        read_chk(A_CTRL, 8'h00, "R1 dir");
    endtask

    task automatic t_timing;
        do_write(A_ECR, 8'hDF);
        #1;
        chk(fifo_rst === 1'b1 && sel_test === 1'b0, "R2 not yet", {fifo_rst, sel_test}, 2'b10);
        @(negedge clk);
        chk(fifo_rst === 1'b0 && sel_test === 1'b1, "R2 effect", {fifo_rst, sel_test}, 2'b01);
        read_chk(A_ECR, 8'hC0, "R2 readback masked");
        set_mode(3'b101);
        read_chk(A_ECR, 8'hA0, "R2 reserved stored");
    endtask

    task automatic t_drivers;
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 2; d++) begin
                bit stdl;
                stdl = (c == 0 || c == 5);
                do_write(A_CTRL, d ? 8'h20 : 8'h00);
                set_mode(3'(c));
                #1;
                if (stdl) begin
                    chk(pd_oe === 1'b1, "R3 pd_oe", pd_oe, 1);
                    chk(ctl_od === 4'hF && fifo_rst === 1'b1, "R3 od/rst", {ctl_od, fifo_rst}, 5'h1F);
                end else begin
                    chk(pd_oe === 1'(!d), "R4 pd_oe", pd_oe, !d);
                    chk(ctl_od === 4'h0 && fifo_rst === 1'b0, "R4 od/rst", {ctl_od, fifo_rst}, 0);
                end
                chk(cfg_en === 1'(c == 7), "R7 cfg_en", cfg_en, c == 7);
            end
        end
        do_write(A_CTRL, 8'hFF);
        read_chk(A_CTRL, 8'h20, "R10 dir readback");
        set_mode(3'b010);
        do_write(A_CTRL, 8'h00);
        #1;
        chk(pd_oe === 1'b1, "R10 dir immediate", pd_oe, 1);
    endtask

    task automatic t_readback;
        pd_in = 8'h3C;
        do_write(A_DATA, 8'h96);
        set_mode(3'b000);
        read_chk(A_DATA, 8'h96, "R5 std latched");
        chk(pd_out === 8'h96, "R5 pd_out", pd_out, 8'h96);
        set_mode(3'b001);
        read_chk(A_DATA, 8'h3C, "R5 ps2 pins");
        set_mode(3'b011);
        read_chk(A_DATA, 8'h96, "R5 ecp latched");
        read_chk(11'h123, 8'h00, "R11 unmapped");
    endtask

    task automatic t_strobes;
        epp_ok = 0;
        set_mode(3'b100);
        #1;
        chk({sel_fifo, sel_ecp, sel_epp, sel_test} === 4'b0000, "R6 epp off", {sel_fifo, sel_ecp, sel_epp, sel_test}, 0);
        epp_ok = 1;
        @(negedge clk);
        chk({sel_fifo, sel_ecp, sel_epp, sel_test} === 4'b0010, "R6 epp on", {sel_fifo, sel_ecp, sel_epp, sel_test}, 4'b0010);
        set_mode(3'b010);
        chk({sel_fifo, sel_ecp, sel_epp, sel_test} === 4'b1000, "R6 fifo", {sel_fifo, sel_ecp, sel_epp, sel_test}, 4'b1000);
        set_mode(3'b011);
        chk({sel_fifo, sel_ecp, sel_epp, sel_test} === 4'b0100, "R6 ecp", {sel_fifo, sel_ecp, sel_epp, sel_test}, 4'b0100);
        set_mode(3'b110);
        chk({sel_fifo, sel_ecp, sel_epp, sel_test} === 4'b0001, "R6 test", {sel_fifo, sel_ecp, sel_epp, sel_test}, 4'b0001);
        epp_ok = 0;
    endtask

    task automatic t_cfg;
        irq_num = 4'd14; dma_num = 3'd2;
        set_mode(3'b000);
        read_chk(A_CFGA, 8'h00, "R7 cfga hidden");
        read_chk(A_CFGB, 8'h00, "R7 cfgb hidden");
        set_mode(3'b111);
        read_chk(A_CFGA, 8'h14, "R7 cfga value");
        read_chk(A_CFGB, 8'h2A, "R8 R9 irq14 dma2");
        do_write(A_CFGA, 8'hFF);
        read_chk(A_CFGA, 8'h14, "R7 cfga write ignored");
        irq_num = 4'd5; dma_num = 3'd3;
        read_chk(A_CFGB, 8'h3B, "R8 irq5 R9 dma3");
        irq_num = 4'd15; dma_num = 3'd5;
        read_chk(A_CFGB, 8'h30, "R8 irq15 R9 other");
        irq_num = 4'd3; dma_num = 3'd1;
        read_chk(A_CFGB, 8'h01, "R8 other R9 dma1");
        irq_num = 4'd7; dma_num = 3'd0;
        read_chk(A_CFGB, 8'h08, "R8 irq7");
    endtask

    task automatic t_same_cycle;
        set_mode(3'b000);
        do_write(A_DATA, 8'hC3);
        pd_in = 8'h5A;
        @(negedge clk);
        wr_en = 1; wr_addr = A_ECR; wr_data = 8'h20;
        rd_en = 1; rd_addr = A_DATA;
        #1;
        chk(rd_data === 8'hC3, "R5 same-cycle old mode", rd_data, 8'hC3);
        @(negedge clk);
        wr_en = 0;
        #1;
        chk(rd_data === 8'hC3, "R2 state not yet", rd_data, 8'hC3);
        @(negedge clk);
        #1;
        chk(rd_data === 8'h5A, "R5 new mode pins", rd_data, 8'h5A);
        rd_en = 0;
        @(negedge clk);
        wr_en = 1; wr_addr = A_ECR; wr_data = 8'hE0;
        rd_en = 1; rd_addr = A_ECR;
        #1;
        chk(rd_data === 8'h20, "R2 same-cycle ecr old", rd_data, 8'h20);
        rd_addr = A_CFGA;
        #1;
        chk(rd_data === 8'h00, "R7 same-cycle cfga", rd_data, 8'h00);
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        #1;
        chk(rd_data === 8'h14, "R7 cfga after switch", rd_data, 8'h14);
        rd_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_drivers();
        t_readback();
        t_strobes();
        t_cfg();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule